// File: doc/BRIEF.md
# MSI Adapter Interrupt Router

This block turns message-signalled interrupt writes into adapter interrupts. Each accepted write carries a data word whose upper bits name a PCI function and whose low bits name one of that function's vectors. The block looks the function up in a small routing table, then sets two flag bits in byte-wide memory: a per-vector indicator bit and a per-function summary bit. It raises an adapter interrupt only when the summary bit was the first one set in its byte.

Both flag updates are read-modify-write operations on an external byte memory. The block keeps a lock signal high from the first read to the last write, so the memory side can keep other agents out of the sequence. A write for a function that is not in the table, or a flag access the memory refuses, produces an error event rather than an interrupt. Reads of the message window return all ones on a constant output.

Routing entries are loaded through a configuration write port, one slot per write. A slot is live while its handle is nonzero.

Top module: `msi_adapter_router`

## Requirements
- R1: The function ID is `msi_data[31:11]` and the vector is `msi_data[10:0]`. Decoding uses no other bits.
- R2: A slot takes part in the lookup only while its handle is nonzero. When several live slots hold the requested function ID, the slot with the lowest index is used.
- R3: The indicator bit number is `n = ind_off + vector`. The byte written is `ind_base + n/8` and the bit set is `8'h80 >> (n % 8)`, so bits count from the most significant bit of each byte.
- R4: The summary bit uses the same addressing rule, built from `sum_base` and `sum_off`.
- R5: For a known function, memory is accessed in a fixed order: indicator read, indicator write of the old byte OR the mask, summary read, then summary write. Each write goes to the byte just read, and `mem_lock` is high on every one of these accesses.
- R6: `irq_valid` pulses for one cycle after the summary write only if the summary byte read back as 8'h00. The interrupt word has bit 31 set, the slot's 3-bit subclass in bits 29:27, and every other bit zero.
- R7: An unknown function ID raises no memory access and no interrupt. Instead it pulses `err_valid` with `err_code` = 16'h0001, `err_fid` = the ID, `err_qual` = vector << 16, and `err_addr` = the write address.
- R8: A memory access answered with `mem_err` pulses `err_valid` with `err_code` = 16'h0002 and zero fid, qualifier and address. An indicator fault still goes on to the summary update. A summary fault ends the sequence with no interrupt.
- R9: `ctrl_rdata` always reads 32'hFFFF_FFFF.
- R10: `msi_ready` drops from the cycle after a write is accepted until the sequence ends. A write offered while `msi_ready` is low is not taken and has no effect.
- R11: After reset, `msi_ready` is high, `irq_valid`, `err_valid` and `mem_req` are low, and every slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msi_valid | input | 1 | Message write offered |
| msi_ready | output | 1 | Block idle; a write is taken when valid and ready are both high |
| msi_data | input | 32 | Message data: function ID and vector |
| msi_addr | input | 32 | Address of the message write, reported in errors |
| ctrl_rdata | output | 32 | Read data of the message window |
| cfg_we | input | 1 | Write one routing slot |
| cfg_slot | input | 5 | Slot index |
| cfg_handle | input | 32 | Handle; nonzero makes the slot live |
| cfg_fid | input | 21 | Function ID of the slot |
| cfg_ind_base | input | 32 | Indicator array byte address |
| cfg_ind_off | input | 16 | Indicator bit offset of the function |
| cfg_sum_base | input | 32 | Summary array byte address |
| cfg_sum_off | input | 16 | Summary bit offset |
| cfg_isc | input | 3 | Interrupt subclass |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Locked read-modify-write in progress |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access could not reach memory (with mem_ack) |
| irq_valid | output | 1 | Adapter interrupt pulse |
| irq_word | output | 32 | Interruption word |
| err_valid | output | 1 | Error event pulse |
| err_code | output | 16 | Event code |
| err_fid | output | 21 | Function ID of the event |
| err_qual | output | 32 | Qualifier word |
| err_addr | output | 32 | Reported address |

## Verification
The assertions assume the memory answers one request at a time and holds `mem_ack` for exactly the cycle in which the request completes. They also assume `mem_err` is only meaningful when `mem_ack` is high. The bench memory model keeps to these rules in both its immediate-answer mode and its every-other-cycle mode. Routing slots are only rewritten while the block is idle, so the table a lookup sees does not change under a sequence in flight.

// File: rtl/msi_route_pkg.sv
package msi_route_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_IND_RD,
      ST_IND_WR,
      ST_SUM_RD,
      ST_SUM_WR
   } rmw_state_t;

   localparam logic [15:0] EVT_NO_TARGET   = 16'h0001;
   localparam logic [15:0] EVT_ROUTE_FAULT = 16'h0002;

   localparam int IRQ_FLAG_BIT = 31;
   localparam int ISC_SHIFT    = 27;

endpackage

// File: rtl/msi_func_table.sv
module msi_func_table #(
   parameter int SLOTS    = 32,
   parameter int FID_W    = 21,
   parameter int HANDLE_W = 32,
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 16,
   parameter int ISC_W    = 3,
   localparam int SLOT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cfg_we,
   input  logic [SLOT_W-1:0]   cfg_slot,
   input  logic [HANDLE_W-1:0] cfg_handle,
   input  logic [FID_W-1:0]    cfg_fid,
   input  logic [ADDR_W-1:0]   cfg_ind_base,
   input  logic [OFF_W-1:0]    cfg_ind_off,
   input  logic [ADDR_W-1:0]   cfg_sum_base,
   input  logic [OFF_W-1:0]    cfg_sum_off,
   input  logic [ISC_W-1:0]    cfg_isc,
   input  logic [FID_W-1:0]    look_fid,
   output logic                hit,
   output logic [ADDR_W-1:0]   hit_ind_base,
   output logic [OFF_W-1:0]    hit_ind_off,
   output logic [ADDR_W-1:0]   hit_sum_base,
   output logic [OFF_W-1:0]    hit_sum_off,
   output logic [ISC_W-1:0]    hit_isc
);

   if (SLOTS < 1) begin : g_bad_slots
      $error("msi_func_table: SLOTS must be at least 1");
   end

   logic [HANDLE_W-1:0] handle_q   [SLOTS];
   logic [FID_W-1:0]    fid_q      [SLOTS];
   logic [ADDR_W-1:0]   ind_base_q [SLOTS];
   logic [OFF_W-1:0]    ind_off_q  [SLOTS];
   logic [ADDR_W-1:0]   sum_base_q [SLOTS];
   logic [OFF_W-1:0]    sum_off_q  [SLOTS];
   logic [ISC_W-1:0]    isc_q      [SLOTS];
   logic [SLOTS-1:0]    match;
   logic [SLOT_W-1:0]   sel;

   wire cfg_in_range = (32'(cfg_slot) < SLOTS);

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < SLOTS; i++) handle_q[i] <= '0;
      end else if (cfg_we && cfg_in_range) begin
         handle_q[cfg_slot] <= cfg_handle;
      end
   end

   always_ff @(posedge clk) begin
      if (cfg_we && cfg_in_range) begin
         fid_q[cfg_slot]      <= cfg_fid;
         ind_base_q[cfg_slot] <= cfg_ind_base;
         ind_off_q[cfg_slot]  <= cfg_ind_off;
         sum_base_q[cfg_slot] <= cfg_sum_base;
         sum_off_q[cfg_slot]  <= cfg_sum_off;
         isc_q[cfg_slot]      <= cfg_isc;
      end
   end

   // One comparator per slot, all in parallel.
   for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
      assign match[g] = (handle_q[g] != '0) && (fid_q[g] == look_fid);
   end

   // Lowest index wins.
   always_comb begin
      sel = '0;
      hit = 1'b0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (match[i]) begin
            sel = SLOT_W'(i);
            hit = 1'b1;
         end
      end
   end

   assign hit_ind_base = ind_base_q[sel];
   assign hit_ind_off  = ind_off_q[sel];
   assign hit_sum_base = sum_base_q[sel];
   assign hit_sum_off  = sum_off_q[sel];
   assign hit_isc      = isc_q[sel];

endmodule

// File: rtl/msi_bit_locator.sv
module msi_bit_locator #(
   parameter int ADDR_W    = 32,
   parameter int BITN_W    = 17,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [BITN_W-1:0] bit_no,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [7:0]        mask
);

   if (BITN_W < 4 || BITN_W > ADDR_W) begin : g_bad_width
      $error("msi_bit_locator: BITN_W must lie in 4..ADDR_W");
   end

   assign byte_addr = base + ADDR_W'(bit_no >> 3);

   if (MSB_FIRST) begin : g_msb_first
      assign mask = 8'h80 >> bit_no[2:0];
   end else begin : g_lsb_first
      assign mask = 8'h01 << bit_no[2:0];
   end

endmodule

// File: rtl/msi_rmw_seq.sv
module msi_rmw_seq
   import msi_route_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int VEC_W  = 11,
   parameter int ADDR_W = 32,
   parameter int ISC_W  = 3,
   parameter int QUAL_VEC_POS = 16,
   localparam int FID_W = DATA_W - VEC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              msi_valid,
   output logic              msi_ready,
   input  logic [DATA_W-1:0] msi_data,
   input  logic [ADDR_W-1:0] msi_addr,
   output logic [FID_W-1:0]  look_fid,
   output logic [VEC_W-1:0]  look_vec,
   input  logic              route_hit,
   input  logic [ADDR_W-1:0] ind_addr,
   input  logic [7:0]        ind_mask,
   input  logic [ADDR_W-1:0] sum_addr,
   input  logic [7:0]        sum_mask,
   input  logic [ISC_W-1:0]  route_isc,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              irq_valid,
   output logic [31:0]       irq_word,
   output logic              err_valid,
   output logic [15:0]       err_code,
   output logic [FID_W-1:0]  err_fid,
   output logic [31:0]       err_qual,
   output logic [ADDR_W-1:0] err_addr
);

   if (QUAL_VEC_POS + VEC_W > 32) begin : g_bad_qual
      $error("msi_rmw_seq: vector does not fit the qualifier word");
   end
   if (ISC_SHIFT + ISC_W > IRQ_FLAG_BIT) begin : g_bad_isc
      $error("msi_rmw_seq: subclass overlaps the interrupt flag");
   end

   rmw_state_t        state_q;
   logic [DATA_W-1:0] data_q;
   logic [ADDR_W-1:0] waddr_q, ind_a_q, sum_a_q;
   logic [7:0]        ind_m_q, sum_m_q, old_q;
   logic [ISC_W-1:0]  isc_q;

   assign look_fid  = data_q[DATA_W-1:VEC_W];
   assign look_vec  = data_q[VEC_W-1:0];
   assign msi_ready = (state_q == ST_IDLE);

   wire on_ind = (state_q == ST_IND_RD) || (state_q == ST_IND_WR);
   wire on_sum = (state_q == ST_SUM_RD) || (state_q == ST_SUM_WR);

   assign mem_req   = on_ind || on_sum;
   assign mem_lock  = mem_req;
   assign mem_we    = (state_q == ST_IND_WR) || (state_q == ST_SUM_WR);
   assign mem_addr  = on_ind ? ind_a_q : sum_a_q;
   assign mem_wdata = old_q | (on_ind ? ind_m_q : sum_m_q);

   wire fault_now  = mem_req && mem_ack && mem_err;
   wire nomsi_now  = (state_q == ST_LOOKUP) && !route_hit;
   wire irq_now    = (state_q == ST_SUM_WR) && mem_ack && !mem_err && (old_q == 8'h00);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         data_q  <= '0;
         waddr_q <= '0;
         ind_a_q <= '0;
         sum_a_q <= '0;
         ind_m_q <= '0;
         sum_m_q <= '0;
         old_q   <= '0;
         isc_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (msi_valid) begin
               data_q  <= msi_data;
               waddr_q <= msi_addr;
               state_q <= ST_LOOKUP;
            end
            ST_LOOKUP: if (route_hit) begin
               ind_a_q <= ind_addr;
               ind_m_q <= ind_mask;
               sum_a_q <= sum_addr;
               sum_m_q <= sum_mask;
               isc_q   <= route_isc;
               state_q <= ST_IND_RD;
            end else begin
               state_q <= ST_IDLE;
            end
            ST_IND_RD: if (mem_ack) begin
               old_q   <= mem_rdata;
               state_q <= mem_err ? ST_SUM_RD : ST_IND_WR;
            end
            ST_IND_WR: if (mem_ack) state_q <= ST_SUM_RD;
            ST_SUM_RD: if (mem_ack) begin
               old_q   <= mem_rdata;
               state_q <= mem_err ? ST_IDLE : ST_SUM_WR;
            end
            ST_SUM_WR: if (mem_ack) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_valid <= 1'b0;
         irq_word  <= '0;
         err_valid <= 1'b0;
         err_code  <= '0;
         err_fid   <= '0;
         err_qual  <= '0;
         err_addr  <= '0;
      end else begin
         irq_valid <= irq_now;
         err_valid <= fault_now || nomsi_now;
         if (irq_now) begin
            irq_word <= (32'(isc_q) << ISC_SHIFT) | (32'h1 << IRQ_FLAG_BIT);
         end
         if (nomsi_now) begin
            err_code <= EVT_NO_TARGET;
            err_fid  <= look_fid;
            err_qual <= 32'(look_vec) << QUAL_VEC_POS;
            err_addr <= waddr_q;
         end else if (fault_now) begin
            err_code <= EVT_ROUTE_FAULT;
            err_fid  <= '0;
            err_qual <= '0;
            err_addr <= '0;
         end
      end
   end

   // R5: every write hits the byte acknowledged by the read just before it
   a_r5_write_after_read: assert property (@(posedge clk) disable iff (rst)
      (mem_req && mem_we && !$past(mem_req && mem_we))
         |-> ($past(mem_req && !mem_we && mem_ack) && mem_addr == $past(mem_addr)));

   // R6: an interrupt only follows a completed write
   a_r6_irq_after_write: assert property (@(posedge clk) disable iff (rst)
      irq_valid |-> $past(mem_req && mem_we && mem_ack));

   // R6: interrupt and error never share a cycle
   a_r6_irq_err_exclusive: assert property (@(posedge clk) disable iff (rst)
      !(irq_valid && err_valid));

   // R7: an unknown function never touched memory
   a_r7_nomsi_no_access: assert property (@(posedge clk) disable iff (rst)
      (err_valid && err_code == EVT_NO_TARGET) |-> $past(!mem_req));

   // R8: a routing fault follows a refused access
   a_r8_fault_after_error: assert property (@(posedge clk) disable iff (rst)
      (err_valid && err_code == EVT_ROUTE_FAULT) |-> $past(mem_req && mem_ack && mem_err));

   // R10: acceptance makes the block busy
   a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
      (msi_valid && msi_ready) |=> !msi_ready);

endmodule

// File: rtl/msi_adapter_router.sv
module msi_adapter_router #(
   parameter int DATA_W       = 32,
   parameter int VEC_W        = 11,
   parameter int SLOTS        = 32,
   parameter int HANDLE_W     = 32,
   parameter int ADDR_W       = 32,
   parameter int OFF_W        = 16,
   parameter int ISC_W        = 3,
   parameter int QUAL_VEC_POS = 16,
   parameter bit MSB_FIRST    = 1'b1,
   localparam int FID_W  = DATA_W - VEC_W,
   localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                msi_valid,
   output logic                msi_ready,
   input  logic [DATA_W-1:0]   msi_data,
   input  logic [ADDR_W-1:0]   msi_addr,
   output logic [31:0]         ctrl_rdata,
   input  logic                cfg_we,
   input  logic [SLOT_W-1:0]   cfg_slot,
   input  logic [HANDLE_W-1:0] cfg_handle,
   input  logic [FID_W-1:0]    cfg_fid,
   input  logic [ADDR_W-1:0]   cfg_ind_base,
   input  logic [OFF_W-1:0]    cfg_ind_off,
   input  logic [ADDR_W-1:0]   cfg_sum_base,
   input  logic [OFF_W-1:0]    cfg_sum_off,
   input  logic [ISC_W-1:0]    cfg_isc,
   output logic                mem_req,
   output logic                mem_we,
   output logic                mem_lock,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [7:0]          mem_wdata,
   input  logic [7:0]          mem_rdata,
   input  logic                mem_ack,
   input  logic                mem_err,
   output logic                irq_valid,
   output logic [31:0]         irq_word,
   output logic                err_valid,
   output logic [15:0]         err_code,
   output logic [FID_W-1:0]    err_fid,
   output logic [31:0]         err_qual,
   output logic [ADDR_W-1:0]   err_addr
);

   localparam int BITN_W = ((OFF_W > VEC_W) ? OFF_W : VEC_W) + 1;

   if (VEC_W < 1 || VEC_W >= DATA_W) begin : g_bad_vec
      $error("msi_adapter_router: VEC_W must lie in 1..DATA_W-1");
   end

   logic [FID_W-1:0]  look_fid;
   logic [VEC_W-1:0]  look_vec;
   logic              hit;
   logic [ADDR_W-1:0] hit_ind_base, hit_sum_base, ind_addr, sum_addr;
   logic [OFF_W-1:0]  hit_ind_off, hit_sum_off;
   logic [ISC_W-1:0]  hit_isc;
   logic [7:0]        ind_mask, sum_mask;
   logic [BITN_W-1:0] ind_bit, sum_bit;

   assign ctrl_rdata = 32'hFFFF_FFFF;
   assign ind_bit    = BITN_W'(hit_ind_off) + BITN_W'(look_vec);
   assign sum_bit    = BITN_W'(hit_sum_off);

   msi_func_table #(
      .SLOTS(SLOTS), .FID_W(FID_W), .HANDLE_W(HANDLE_W),
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ISC_W(ISC_W)
   ) i_table (
      .clk, .rst, .cfg_we, .cfg_slot, .cfg_handle, .cfg_fid,
      .cfg_ind_base, .cfg_ind_off, .cfg_sum_base, .cfg_sum_off, .cfg_isc,
      .look_fid, .hit, .hit_ind_base, .hit_ind_off,
      .hit_sum_base, .hit_sum_off, .hit_isc
   );

   msi_bit_locator #(.ADDR_W(ADDR_W), .BITN_W(BITN_W), .MSB_FIRST(MSB_FIRST)) i_ind_loc (
      .base(hit_ind_base), .bit_no(ind_bit), .byte_addr(ind_addr), .mask(ind_mask)
   );

   msi_bit_locator #(.ADDR_W(ADDR_W), .BITN_W(BITN_W), .MSB_FIRST(MSB_FIRST)) i_sum_loc (
      .base(hit_sum_base), .bit_no(sum_bit), .byte_addr(sum_addr), .mask(sum_mask)
   );

   msi_rmw_seq #(
      .DATA_W(DATA_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
      .ISC_W(ISC_W), .QUAL_VEC_POS(QUAL_VEC_POS)
   ) i_seq (
      .clk, .rst, .msi_valid, .msi_ready, .msi_data, .msi_addr,
      .look_fid, .look_vec, .route_hit(hit),
      .ind_addr, .ind_mask, .sum_addr, .sum_mask, .route_isc(hit_isc),
      .mem_req, .mem_we, .mem_lock, .mem_addr, .mem_wdata,
      .mem_rdata, .mem_ack, .mem_err,
      .irq_valid, .irq_word, .err_valid, .err_code, .err_fid, .err_qual, .err_addr
   );

   // R5: the lock covers every memory access
   a_r5_lock_held: assert property (@(posedge clk) disable iff (rst)
      mem_req |-> mem_lock);

   // R9: the message window reads as all ones
   a_r9_window_ones: assert property (@(posedge clk) disable iff (rst)
      ctrl_rdata == 32'hFFFF_FFFF);

endmodule

// File: tb/test_msi_adapter_router.sv
`timescale 1ns/1ps
module test_msi_adapter_router;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        msi_valid = 1'b0;
   logic        msi_ready;
   logic [31:0] msi_data = '0;
   logic [31:0] msi_addr = '0;
   logic [31:0] ctrl_rdata;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_slot = '0;
   logic [31:0] cfg_handle = '0;
   logic [20:0] cfg_fid = '0;
   logic [31:0] cfg_ind_base = '0;
   logic [15:0] cfg_ind_off = '0;
   logic [31:0] cfg_sum_base = '0;
   logic [15:0] cfg_sum_off = '0;
   logic [2:0]  cfg_isc = '0;
   logic        mem_req, mem_we, mem_lock, mem_ack, mem_err;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        irq_valid, err_valid;
   logic [31:0] irq_word, err_qual, err_addr;
   logic [15:0] err_code;
   logic [20:0] err_fid;

   always #4 clk = ~clk;

   msi_adapter_router i_msi_adapter_router (
      .clk, .rst, .msi_valid, .msi_ready, .msi_data, .msi_addr, .ctrl_rdata,
      .cfg_we, .cfg_slot, .cfg_handle, .cfg_fid, .cfg_ind_base, .cfg_ind_off,
      .cfg_sum_base, .cfg_sum_off, .cfg_isc,
      .mem_req, .mem_we, .mem_lock, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .mem_err,
      .irq_valid, .irq_word, .err_valid, .err_code, .err_fid, .err_qual, .err_addr
   );

   // Byte memory: 512 bytes, anything above is unreachable
   logic [7:0] mem [0:511];
   logic [7:0] exp_mem [0:511];
   logic       slow = 1'b0;
   logic       tick = 1'b0;
   wire        bad = (mem_addr >= 32'd512);

   assign mem_ack   = mem_req && (!slow || tick);
   assign mem_err   = mem_req && bad;
   assign mem_rdata = bad ? 8'h00 : mem[mem_addr[8:0]];

   always @(posedge clk) begin
      tick <= ~tick;
      if (mem_req && mem_we && mem_ack && !bad) mem[mem_addr[8:0]] <= mem_wdata;
   end

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %0h exp %0h", req, got, exp);
      end
   endtask

   // Scoreboard
   typedef struct {
      bit          is_irq;
      logic [31:0] word;
      logic [15:0] code;
      logic [20:0] fid;
      logic [31:0] qual;
      logic [31:0] addr;
      string       req;
   } exp_t;
   exp_t q[$];

   function automatic void push(bit irq, logic [31:0] w, logic [15:0] c, logic [20:0] f,
                                logic [31:0] ql, logic [31:0] ad, string r);
      exp_t e;
      e.is_irq = irq; e.word = w; e.code = c; e.fid = f; e.qual = ql; e.addr = ad; e.req = r;
      q.push_back(e);
   endfunction

   always @(negedge clk) begin
      if (!rst && (irq_valid || err_valid)) begin
         if (q.size() == 0) begin
            chk(1'b0, "R6 unexpected event", {irq_valid, err_valid}, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (e.is_irq)
               chk(irq_valid && irq_word == e.word, e.req, {irq_valid, irq_word}, {1'b1, e.word});
            else
               chk(err_valid && err_code == e.code && err_fid == e.fid &&
                   err_qual == e.qual && err_addr == e.addr, e.req,
                   {err_valid, err_code, err_fid, err_qual, err_addr},
                   {1'b1, e.code, e.fid, e.qual, e.addr});
         end
      end
   end

   // Bench copy of the routing slots
   int b_handle [32];
   int b_fid    [32];
   int b_ib     [32];
   int b_io     [32];
   int b_sb     [32];
   int b_so     [32];
   int b_isc    [32];

   task automatic cfg(input int s, input int h, input int f, input int ib, input int io,
                      input int sb, input int so, input int isc);
      @(negedge clk);
      cfg_we = 1'b1; cfg_slot = 5'(s); cfg_handle = 32'(h); cfg_fid = 21'(f);
      cfg_ind_base = 32'(ib); cfg_ind_off = 16'(io);
      cfg_sum_base = 32'(sb); cfg_sum_off = 16'(so); cfg_isc = 3'(isc);
      b_handle[s] = h; b_fid[s] = f; b_ib[s] = ib; b_io[s] = io;
      b_sb[s] = sb; b_so[s] = so; b_isc[s] = isc;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Expected outcome from the requirements (R2, R3, R4, R6, R7, R8)
   task automatic predict(input int f, input int v, input logic [31:0] a);
      int s, ib, ia, sa;
      logic [7:0] old;
      s = -1;
      for (int i = 0; i < 32; i++)
         if (s < 0 && b_handle[i] != 0 && b_fid[i] == f) s = i;
      if (s < 0) begin
         push(1'b0, 0, 16'h0001, 21'(f), 32'(v) << 16, a, "R7 no target");
      end else begin
         ib = b_io[s] + v;
         ia = b_ib[s] + ib / 8;
         if (ia >= 512) push(1'b0, 0, 16'h0002, 0, 0, 0, "R8 indicator fault");
         else exp_mem[ia] = exp_mem[ia] | (8'h80 >> (ib % 8));
         sa = b_sb[s] + b_so[s] / 8;
         if (sa >= 512) push(1'b0, 0, 16'h0002, 0, 0, 0, "R8 summary fault");
         else begin
            old = exp_mem[sa];
            exp_mem[sa] = old | (8'h80 >> (b_so[s] % 8));
            if (old == 8'h00) push(1'b1, 32'h8000_0000 | (32'(b_isc[s]) << 27), 0, 0, 0, 0, "R6 interrupt");
         end
      end
   endtask

   // Drive one message write; optionally offer a second write while busy (R10)
   task automatic send(input int f, input int v, input logic [31:0] a, input bit poke_busy);
      predict(f, v, a);
      @(negedge clk);
      while (!msi_ready) @(negedge clk);
      msi_valid = 1'b1;
      msi_data  = {21'(f), 11'(v)};
      msi_addr  = a;
      @(negedge clk);
      msi_valid = 1'b0;
      chk(!msi_ready, "R10 busy after accept", msi_ready, 0);
      if (poke_busy) begin
         msi_valid = 1'b1;
         msi_data  = {21'd99, 11'h155};
         msi_addr  = 32'hBAD0_0000;
         @(negedge clk);
         msi_valid = 1'b0;
      end
      while (!msi_ready) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 512; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
      for (int i = 0; i < 32; i++) begin
         b_handle[i] = 0; b_fid[i] = 0; b_ib[i] = 0; b_io[i] = 0;
         b_sb[i] = 0; b_so[i] = 0; b_isc[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R11 reset state, R9 window read
      chk(msi_ready && !irq_valid && !err_valid && !mem_req, "R11 reset state",
          {msi_ready, irq_valid, err_valid, mem_req}, 4'b1000);
      chk(ctrl_rdata == 32'hFFFF_FFFF, "R9 window read", ctrl_rdata, 32'hFFFF_FFFF);

      // R11 empty table: any function is unknown
      send(5, 'h12, 32'h1000_0000, 1'b0);

      // Routing slots
      cfg(0,  0, 5,       'h000, 0,  'h000, 0, 0);  // handle zero: not live (R2)
      cfg(3,  1, 5,       'h010, 0,  'h080, 3, 5);
      cfg(7,  2, 5,       'h040, 9,  'h088, 0, 1);  // duplicate ID, higher index (R2)
      cfg(9,  3, 'h12345, 'h020, 13, 'h090, 7, 7);
      cfg(12, 4, 9,       'h1F0, 0,  'h0A0, 0, 2);
      cfg(13, 5, 10,      'h030, 4,  'h300, 0, 3);
      cfg(20, 6, 'h1FFFFF,'h100, 0,  'h1FE, 8, 4);

      send(5, 0, 32'h0, 1'b0);                   // R2 R3 R4 R6 first summary: interrupt
      send(5, 1, 32'h0, 1'b0);                   // R6 summary already set: no interrupt
      slow = 1'b1;
      send('h12345, 'h7FF, 32'h0, 1'b0);         // R1 R3 max vector with offset, stalled memory
      slow = 1'b0;
      send(99, 'h2AB, 32'hDEAD_0000, 1'b0);      // R7 unknown function
      send(9, 'h100, 32'h0, 1'b0);               // R8 indicator fault then interrupt
      send(10, 3, 32'h0, 1'b0);                  // R8 summary fault: no interrupt
      send('h1FFFFF, 'h7FF, 32'h0, 1'b0);        // R1 R6 summary byte already nonzero
      cfg(3, 0, 5, 'h010, 0, 'h080, 3, 5);       // retire slot 3
      send(5, 2, 32'h0, 1'b0);                   // R2 falls to slot 7
      send(5, 3, 32'h0, 1'b1);                   // R10 write offered while busy is ignored

      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R10 all expected events seen, none extra", q.size(), 0);
      begin
         int mism = 0;
         for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) mism++;
         chk(mism == 0, "R5 memory contents", mism, 0);
      end
      chk(mem['h010] == 8'hC0, "R3 indicator byte", mem['h010], 8'hC0);
      chk(mem['h080] == 8'h10, "R4 summary byte", mem['h080], 8'h10);
      chk(mem['h041] == 8'h18, "R3 second slot indicator", mem['h041], 8'h18);
      chk(ctrl_rdata == 32'hFFFF_FFFF, "R9 window read later", ctrl_rdata, 32'hFFFF_FFFF);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule